// File: doc/BRIEF.md
# Single-Cycle Integer Core With Host Status Register

This block is a small unpipelined processor core that fetches, decodes, executes and retires one instruction on every rising clock edge. It executes five instruction kinds from a MIPS-style 32-bit encoding: add-immediate-unsigned, load word, store word, branch-if-not-equal, and a coprocessor move that writes an 8-bit host status register. Every other opcode is treated as a no-operation.

Instruction memory and data memory sit outside the core and are read combinationally. The core drives the instruction address and receives the instruction word in the same cycle. It drives a data address, write data and a write strobe, and gets load data back in that same cycle. Test software signals its verdict through the host status output: 1 means the program passed and any larger value identifies a failure.

Top module: `smx_core`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, the instruction address is 0x00001000, the host status output is 0, `dmem_we` is low, and all 32 general registers read as zero.
- R2: An instruction other than a taken branch moves the instruction address to the current address plus 4 at the next rising edge. Exactly one instruction retires per cycle.
- R3: Opcode 0x05 (bits [31:26]) compares the register addressed by bits [25:21] with the register addressed by bits [20:16]. When the values differ, the next address is current+4 plus the sign-extended bits [15:0] shifted left by 2. When they are equal, the next address is current+4.
- R4: Opcode 0x09 writes the register at bits [20:16] with the register at bits [25:21] plus sign-extended bits [15:0], wrapping modulo 2^32.
- R5: Opcode 0x23 drives `dmem_addr` with base register [25:21] plus the sign-extended offset, and writes `dmem_rdata` from that same cycle into register [20:16].
- R6: Opcode 0x2B raises `dmem_we` for that cycle. It drives `dmem_addr` with base plus the sign-extended offset and `dmem_wdata` with register [20:16]. `dmem_we` is low for every other instruction.
- R7: Opcode 0x10 with bits [25:21] = 0x04 and bits [15:11] = 21 loads the host status output with the low 8 bits of register [20:16] at the next edge. The same instruction with any other [15:11] value leaves the host status unchanged.
- R8: Register 0 always reads as zero, and writes addressed to it are dropped.
- R9: Any other opcode, or opcode 0x10 with bits [25:21] not equal to 0x04, changes no register, memory or host status and advances the address by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Address of the instruction being executed (the PC) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Effective address for load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, written at the rising edge |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, same cycle |
| tohost | output | 8 | Host status register: 0 idle, 1 pass, >1 fail |

## Verification
The assertions check the following on every cycle: the PC reset value, sequential and taken-branch PC updates, write-through into the register array, that register 0 always holds zero, that the store strobe appears only for the store opcode, and that the host status holds still unless a matching move was decoded. Only the bench's lockstep reference model can show that arithmetic results, loaded data and forwarded register values are correct. It sees them as later store data, effective addresses and host status values across directed and random programs, including wrap-around sums, backward branches, loads that follow stores, and moves to the wrong coprocessor register.

// File: rtl/smx_pkg.sv
package smx_pkg;
    localparam int unsigned XLEN = 32;
    localparam int unsigned NREG = 32;
    localparam int unsigned RAW  = $clog2(NREG);
    localparam int unsigned IMMW = 16;
    localparam int unsigned OPW  = 6;

    localparam logic [OPW-1:0] OPC_ADDIU = 6'h09;
    localparam logic [OPW-1:0] OPC_LW    = 6'h23;
    localparam logic [OPW-1:0] OPC_SW    = 6'h2B;
    localparam logic [OPW-1:0] OPC_BNE   = 6'h05;
    localparam logic [OPW-1:0] OPC_COP0  = 6'h10;
    localparam logic [RAW-1:0] COP0_MOVE_TO = 5'h04;

    typedef enum logic { WB_SUM = 1'b0, WB_LOAD = 1'b1 } wb_sel_e;

    typedef struct packed {
        logic    rf_we;
        wb_sel_e wb_sel;
        logic    mem_we;
        logic    is_bne;
        logic    th_we;
    } ctrl_t;

    typedef struct packed {
        logic [OPW-1:0]  op;
        logic [RAW-1:0]  rs;
        logic [RAW-1:0]  rt;
        logic [RAW-1:0]  rd;
        logic [IMMW-1:0] imm;
    } ifields_t;

    function automatic ifields_t crack(input logic [XLEN-1:0] w);
        ifields_t f;
        f.op  = w[31:26];
        f.rs  = w[25:21];
        f.rt  = w[20:16];
        f.rd  = w[15:11];
        f.imm = w[15:0];
        return f;
    endfunction

    function automatic logic [XLEN-1:0] sext(input logic [IMMW-1:0] v);
        return {{(XLEN-IMMW){v[IMMW-1]}}, v};
    endfunction

    function automatic ctrl_t decode(input ifields_t f, input logic [RAW-1:0] th_sel);
        ctrl_t c;
        c = '0;
        case (f.op)
            OPC_ADDIU: begin c.rf_we = 1'b1; c.wb_sel = WB_SUM;  end
            OPC_LW:    begin c.rf_we = 1'b1; c.wb_sel = WB_LOAD; end
            OPC_SW:    c.mem_we = 1'b1;
            OPC_BNE:   c.is_bne = 1'b1;
            OPC_COP0:  c.th_we = (f.rs == COP0_MOVE_TO) && (f.rd == th_sel);
            default:   c = '0;
        endcase
        return c;
    endfunction
endpackage

// File: rtl/smx_decode.sv
module smx_decode
    import smx_pkg::*;
#(
    parameter logic [RAW-1:0] TH_SEL = 5'd21
) (
    input  logic [XLEN-1:0] instr,
    output ifields_t        fld,
    output ctrl_t           ctl,
    output logic [XLEN-1:0] imm_x
);
    always_comb begin
        fld   = crack(instr);
        ctl   = decode(fld, TH_SEL);
        imm_x = sext(fld.imm);
    end
endmodule

// File: rtl/smx_regfile.sv
module smx_regfile
    import smx_pkg::*;
#(
    parameter int unsigned NRD = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [RAW-1:0]  raddr [NRD],
    output logic [XLEN-1:0] rdata [NRD],
    input  logic            we,
    input  logic [RAW-1:0]  waddr,
    input  logic [XLEN-1:0] wdata
);
    logic [XLEN-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = (raddr[p] == '0) ? '0 : regs[raddr[p]];
    end

    // R8: the zero register never picks up a value
    a_r8_zero_entry: assert property (@(posedge clk) disable iff (rst)
        regs[0] == '0);

    // R4: a write to a non-zero register is visible at the next edge
    a_r4_write_lands: assert property (@(posedge clk) disable iff (rst)
        (we && (waddr != '0)) |=> (regs[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/smx_pcunit.sv
module smx_pcunit
    import smx_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = 32'h0000_1000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            taken,
    input  logic [XLEN-1:0] imm_x,
    output logic [XLEN-1:0] pc
);
    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    logic [XLEN-1:0] pc_q, pc_inc, pc_tgt;

    always_comb begin
        pc_inc = pc_q + STEP;
        pc_tgt = pc_inc + {imm_x[XLEN-3:0], 2'b00};
    end

    always_ff @(posedge clk) begin
        if (rst)        pc_q <= RESET_PC;
        else if (taken) pc_q <= pc_tgt;
        else            pc_q <= pc_inc;
    end

    assign pc = pc_q;

    a_r1_reset_pc: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc_q == RESET_PC));

    a_r2_sequential: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(taken)) |-> (pc_q == $past(pc_q) + STEP));

    a_r3_branch_target: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(taken)) |->
        (pc_q == $past(pc_q) + STEP + ($past(imm_x) << 2)));
endmodule

// File: rtl/smx_core.sv
module smx_core
    import smx_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC   = 32'h0000_1000,
    parameter logic [RAW-1:0]  TOHOST_SEL = 5'd21,
    parameter int unsigned     TOHOST_W   = 8
) (
    input  logic                clk,
    input  logic                rst,
    output logic [XLEN-1:0]     imem_addr,
    input  logic [XLEN-1:0]     imem_rdata,
    output logic [XLEN-1:0]     dmem_addr,
    output logic [XLEN-1:0]     dmem_wdata,
    output logic                dmem_we,
    input  logic [XLEN-1:0]     dmem_rdata,
    output logic [TOHOST_W-1:0] tohost
);
    ifields_t        fld;
    ctrl_t           ctl;
    logic [XLEN-1:0] imm_x;
    logic [RAW-1:0]  rf_ra [2];
    logic [XLEN-1:0] rf_rd [2];
    logic [XLEN-1:0] sum, wb_data;
    logic            taken;
    logic [TOHOST_W-1:0] tohost_q;

    smx_decode #(.TH_SEL(TOHOST_SEL)) u_dec (
        .instr (imem_rdata),
        .fld   (fld),
        .ctl   (ctl),
        .imm_x (imm_x)
    );

    assign rf_ra[0] = fld.rs;
    assign rf_ra[1] = fld.rt;

    always_comb begin
        sum     = rf_rd[0] + imm_x;
        wb_data = (ctl.wb_sel == WB_LOAD) ? dmem_rdata : sum;
        taken   = ctl.is_bne && (rf_rd[0] != rf_rd[1]);
    end

    smx_regfile #(.NRD(2)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .raddr (rf_ra),
        .rdata (rf_rd),
        .we    (ctl.rf_we),
        .waddr (fld.rt),
        .wdata (wb_data)
    );

    smx_pcunit #(.RESET_PC(RESET_PC)) u_pc (
        .clk   (clk),
        .rst   (rst),
        .taken (taken),
        .imm_x (imm_x),
        .pc    (imem_addr)
    );

    always_ff @(posedge clk) begin
        if (rst)             tohost_q <= '0;
        else if (ctl.th_we)  tohost_q <= rf_rd[1][TOHOST_W-1:0];
    end

    assign tohost     = tohost_q;
    assign dmem_addr  = sum;
    assign dmem_wdata = rf_rd[1];
    assign dmem_we    = ctl.mem_we && !rst;

    // R6: the store strobe only accompanies the store opcode
    a_r6_store_gate: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> (imem_rdata[31:26] == OPC_SW));

    // R7: host status moves only after a matching coprocessor move
    a_r7_tohost_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ctl.th_we)) |-> $stable(tohost_q));
endmodule

// File: tb/smx_core_tb.sv
`timescale 1ns/1ps
module smx_core_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;
    logic [7:0]  tohost;

    always #4 clk = ~clk;

    smx_core u_dut (
        .clk(clk), .rst(rst),
        .imem_addr(imem_addr), .imem_rdata(imem_rdata),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
        .dmem_rdata(dmem_rdata), .tohost(tohost)
    );

    int          n_cmp = 0;
    int          n_bad = 0;
    logic [31:0] prog   [64];
    logic [31:0] m_dmem [64];
    logic [31:0] m_reg  [32];
    logic [31:0] m_pc;
    logic [7:0]  m_th;
    string       last_tag;

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] enc_mt(input logic [4:0] rt, input logic [4:0] rd);
        return {6'h10, 5'h04, rt, rd, 11'd0};
    endfunction

    function automatic logic [31:0] sx(input logic [15:0] i);
        return {{16{i[15]}}, i};
    endfunction

    function automatic logic [31:0] rget(input logic [4:0] a);
        return (a == 5'd0) ? 32'd0 : m_reg[a];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rset(input logic [4:0] a, input logic [31:0] v);
        if (a != 5'd0) m_reg[a] = v;   // R8: writes to r0 dropped
    endtask

    // Executes one instruction in lockstep; called just after a falling edge.
    task automatic step();
        logic [31:0] ins, a, b, s, npc;
        logic [5:0]  op;
        logic [4:0]  rs, rt, rd;
        chk(last_tag, imem_addr, m_pc);
        chk("R4 R7 tohost", {24'd0, tohost}, {24'd0, m_th});
        ins = prog[m_pc[7:2]];
        op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
        a = rget(rs); b = rget(rt); s = a + sx(ins[15:0]);
        imem_rdata = ins;
        dmem_rdata = m_dmem[s[7:2]];
        #1;
        chk("R6 store strobe", {31'd0, dmem_we}, {31'd0, op == 6'h2B});
        npc = m_pc + 32'd4;
        last_tag = "R2 pc advance";
        case (op)
            6'h09: rset(rt, s);
            6'h23: begin
                chk("R5 load address", dmem_addr, s);
                rset(rt, m_dmem[s[7:2]]);
            end
            6'h2B: begin
                chk("R6 store address", dmem_addr, s);
                chk((rt == 5'd0) ? "R8 r0 store data" : "R6 store data", dmem_wdata, b);
                m_dmem[s[7:2]] = b;
            end
            6'h05: begin
                last_tag = "R3 branch pc";
                if (a != b) npc = m_pc + 32'd4 + (sx(ins[15:0]) << 2);
            end
            6'h10: begin
                if (rs == 5'h04 && rd == 5'd21) m_th = b[7:0];
                else last_tag = "R9 inert move pc";
            end
            default: last_tag = "R9 unknown op pc";
        endcase
        m_pc = npc;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        imem_rdata = enc_i(6'h2B, 5'd0, 5'd0, 16'd0);
        dmem_rdata = 32'd0;
        m_pc = 32'h0000_1000;
        m_th = 8'd0;
        for (int i = 0; i < 32; i++) m_reg[i] = 32'd0;
        last_tag = "R1 pc after reset";
        repeat (3) @(negedge clk);
        chk("R1 pc held in reset", imem_addr, 32'h0000_1000);
        chk("R1 tohost in reset", {24'd0, tohost}, 32'd0);
        chk("R1 no store in reset", {31'd0, dmem_we}, 32'd0);
        rst = 1'b0;
    endtask

    function automatic logic [31:0] gen_instr();
        int unsigned k;
        logic [4:0]  rs, rt;
        logic [15:0] imm;
        k = $urandom_range(0, 11);
        rs = 5'($urandom_range(0, 7));
        rt = 5'($urandom_range(0, 7));
        imm = 16'($urandom);
        case (k)
            0, 1, 2, 11: return enc_i(6'h09, rs, rt, imm);
            3, 4:        return enc_i(6'h23, rs, rt, imm);
            5, 6:        return enc_i(6'h2B, rs, rt, imm);
            7, 8:        return enc_i(6'h05, 5'($urandom_range(0, 2)), 5'($urandom_range(0, 2)),
                                      16'($signed($urandom_range(0, 12)) - 6));
            9:           return enc_mt(rt, ($urandom_range(0, 1) == 1) ? 5'd21 : 5'($urandom_range(0, 31)));
            default: begin
                case ($urandom_range(0, 2))
                    0:       return enc_i(6'h3F, rs, rt, imm);
                    1:       return enc_i(6'h0F, rs, rt, imm);
                    default: return enc_i(6'h10, 5'd0, rt, {5'd21, 11'd0});
                endcase
            end
        endcase
    endfunction

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL R2 watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed_val;
        seed_val = $urandom(32'd20240607);
        imem_rdata = 32'd0;
        dmem_rdata = 32'd0;
        @(negedge clk);

        // Directed: r0 writes, wrap-around add, host moves, unknown op, load after store
        for (int i = 0; i < 64; i++) begin prog[i] = 32'd0; m_dmem[i] = 32'hA5A5_0000 + 32'(i); end
        prog[0] = enc_i(6'h09, 5'd0, 5'd0, 16'd5);
        prog[1] = enc_i(6'h09, 5'd0, 5'd1, 16'hFFFF);
        prog[2] = enc_i(6'h2B, 5'd0, 5'd0, 16'd0);
        prog[3] = enc_i(6'h09, 5'd1, 5'd2, 16'd2);
        prog[4] = enc_mt(5'd2, 5'd21);
        prog[5] = enc_mt(5'd1, 5'd20);
        prog[6] = enc_i(6'h3F, 5'd1, 5'd1, 16'd7);
        prog[7] = enc_i(6'h2B, 5'd0, 5'd1, 16'd4);
        prog[8] = enc_i(6'h23, 5'd0, 5'd3, 16'd4);
        prog[9] = enc_i(6'h2B, 5'd0, 5'd3, 16'd8);
        prog[10] = enc_i(6'h2B, 5'd0, 5'd2, 16'd12);
        do_reset();
        for (int i = 0; i < 14; i++) step();
        chk("R7 tohost pass value", {24'd0, tohost}, 32'd1);

        // Directed: forward, not-taken and backward branches, then a fail code
        for (int i = 0; i < 64; i++) prog[i] = 32'd0;
        prog[0] = enc_i(6'h09, 5'd0, 5'd1, 16'd3);
        prog[1] = enc_i(6'h05, 5'd1, 5'd0, 16'd2);
        prog[2] = enc_i(6'h09, 5'd0, 5'd7, 16'd9);
        prog[3] = enc_i(6'h09, 5'd0, 5'd7, 16'd9);
        prog[4] = enc_i(6'h05, 5'd0, 5'd0, 16'd5);
        prog[5] = enc_i(6'h09, 5'd1, 5'd1, 16'hFFFF);
        prog[6] = enc_i(6'h05, 5'd1, 5'd0, 16'hFFFE);
        prog[7] = enc_i(6'h09, 5'd0, 5'd4, 16'd2);
        prog[8] = enc_mt(5'd4, 5'd21);
        prog[9] = enc_i(6'h2B, 5'd0, 5'd7, 16'd0);
        do_reset();
        for (int i = 0; i < 20; i++) step();
        chk("R3 backward loop exit pc", imem_addr, m_pc);
        chk("R7 tohost fail value", {24'd0, tohost}, 32'd2);

        // Random programs
        for (int r = 0; r < 6; r++) begin
            for (int i = 0; i < 64; i++) begin
                prog[i] = gen_instr();
                m_dmem[i] = $urandom;
            end
            do_reset();
            for (int i = 0; i < 1500; i++) step();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule